// File: doc/BRIEF.md
# Interval Timer Register Port

This block is the byte-wide host interface of a three-channel interval timer. A host issues byte writes and reads on a two-bit address. Address 3 carries control commands. Addresses 0 to 2 carry count data for the matching channel. The counting datapaths sit outside this block.

For each channel the block holds three settings: the access type, the counting mode and the BCD flag. It carries out single-channel latch commands and multi-channel read-back commands. It builds 16-bit start values out of byte writes and sends them to the channel with a one-cycle load strobe. On reads it returns bytes in a fixed priority: a captured status byte first, then the bytes of a captured count, then bytes of the channel's live count.

Toward the channels it drives the load strobes, the load values, and each channel's mode and BCD flag. From the channels it takes the live counts, the OUT levels, and a "value taken" pulse that clears the null-count flag.

Top module: `ivt_port`

## Requirements
- R1: After reset every channel has access type word (code 3), mode 0 and BCD 0. No count or status is captured, the null-count flag is 0, and no load strobe or read-valid is active.
- R2: A write to address 3 whose bits 7:6 name channel 0 to 2 and whose bits 5:4 are nonzero is a control word. It stores the access type from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), the mode from bits 3:1 and BCD from bit 0. The chMode and chBcd outputs change only after such a write.
- R3: Mode codes 6 and 7 are stored as 2 and 3. No channel's mode output is ever above 5.
- R4: A control write with bits 5:4 equal to 0 captures that channel's live count. Later reads return the captured bytes according to the access type: word access gives the low byte, then the high byte. After that, reads return live bytes again.
- R5: A control write with bits 7:6 equal to 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low captures the count and bit 4 low captures the status of every selected channel. Channels that are not selected are left untouched.
- R6: The status byte holds OUT in bit 7, null count in bit 6, the access type in bits 5:4, the mode in bits 3:1 and BCD in bit 0, all sampled when the capture happens.
- R7: A count capture is ignored while a captured count is still unread. A status capture is ignored while a captured status is still unread.
- R8: A data read returns the captured status if there is one, otherwise the captured count, otherwise the live count. Each captured item is dropped once it has been read.
- R9: A low-only write loads the byte zero-extended. A high-only write loads the byte shifted left by 8. A word write loads nothing on the first byte and loads {second, first} on the second. Each load raises exactly one chLoad bit for one cycle, with chLoadValue holding the value, in the cycle after the write.
- R10: Live reads return the low byte for low-only access and the high byte for high-only access. For word access they alternate low, high, low, and so on.
- R11: A count load sets the channel's null-count flag. A pulse on chLoaded clears it.
- R12: Read data appears on rdData with rdValid one cycle after rdEn. A read of address 3 returns 0x00. When rdEn and wrEn are both high, only the write is carried out and rdValid stays low.
- R13: A control word resets the channel's write and read byte toggles to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one byte |
| rdEn | input | 1 | Read strobe for one byte |
| addr | input | 2 | 0 to 2 select a channel's data, 3 selects control |
| wrData | input | 8 | Byte being written |
| rdData | output | 8 | Byte being read, registered |
| rdValid | output | 1 | rdData is valid this cycle |
| chLoad | output | 3 | One-cycle load strobe per channel |
| chLoadValue | output | 48 | 16-bit start value per channel, channel 0 in the low bits |
| chLiveCount | input | 48 | 16-bit live count per channel |
| chOut | input | 3 | OUT level per channel |
| chLoaded | input | 3 | Pulse when a channel has taken its start value |
| chMode | output | 9 | 3-bit mode per channel |
| chBcd | output | 3 | BCD flag per channel |

## Verification
On every cycle the assertions check four properties. Load strobes are one-hot and always follow a data write. The load value never changes without a strobe. Mode outputs stay at 5 or below and change only after a control write. Read-valid follows a read that had no write alongside it, and a read of the control address returns 0. The bench scenarios are the only place to see anything that depends on a sequence of accesses. That covers the byte order of captured and live reads, a second capture being ignored, the status-before-count priority, read-back channel selection, word assembly across two writes, toggle resets on a control word, and the null-count flag rising and falling.

// File: rtl/ivt_port_pkg.sv
package ivt_port_pkg;
  localparam int NUM_CH  = 3;
  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 2 * BYTE_W;
  localparam int MODE_W  = 3;

  typedef enum logic [1:0] {
    ACC_CAPTURE = 2'd0,
    ACC_LO      = 2'd1,
    ACC_HI      = 2'd2,
    ACC_WORD    = 2'd3
  } access_e;

  typedef struct packed {
    logic [NUM_CH-1:0] cfgWr;
    logic [NUM_CH-1:0] cntCap;
    logic [NUM_CH-1:0] stsCap;
    logic [NUM_CH-1:0] dataWr;
    logic [NUM_CH-1:0] dataRd;
    logic              ctlRd;
    access_e           access;
    logic [MODE_W-1:0] mode;
    logic              bcd;
    logic [BYTE_W-1:0] wrByte;
  } portStrobe_t;
endpackage

// File: rtl/ivt_port_decode.sv
module ivt_port_decode
  import ivt_port_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wrData,
  output portStrobe_t       strb
);
  logic [1:0] chSel;
  assign chSel = wrData[7:6];

  always_comb begin
    strb        = '0;
    strb.wrByte = wrData;
    strb.access = access_e'(wrData[5:4]);
    strb.bcd    = wrData[0];
    // fold 6 -> 2 and 7 -> 3
    strb.mode   = {wrData[3] & ~wrData[2], wrData[2:1]};
    if (wrEn) begin
      if (addr == 2'd3) begin
        if (chSel == 2'd3) begin
          for (int c = 0; c < NUM_CH; c++) begin
            if (wrData[c+1]) begin
              strb.cntCap[c] = ~wrData[5];
              strb.stsCap[c] = ~wrData[4];
            end
          end
        end else if (wrData[5:4] == 2'd0) begin
          strb.cntCap[chSel] = 1'b1;
        end else begin
          strb.cfgWr[chSel] = 1'b1;
        end
      end else begin
        strb.dataWr[addr] = 1'b1;
      end
    end else if (rdEn) begin
      if (addr == 2'd3) strb.ctlRd = 1'b1;
      else              strb.dataRd[addr] = 1'b1;
    end
  end
endmodule

// File: rtl/ivt_port_regs.sv
module ivt_port_regs
  import ivt_port_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  portStrobe_t                strb,
  input  logic [NUM_CH*COUNT_W-1:0]  chLiveCount,
  input  logic [NUM_CH-1:0]          chOut,
  input  logic [NUM_CH-1:0]          chLoaded,
  output logic [NUM_CH-1:0]          chLoad,
  output logic [NUM_CH*COUNT_W-1:0]  chLoadValue,
  output logic [NUM_CH*MODE_W-1:0]   chMode,
  output logic [NUM_CH-1:0]          chBcd,
  output logic [BYTE_W-1:0]          rdData,
  output logic                       rdValid
);
  logic [NUM_CH*BYTE_W-1:0] chBytes;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    access_e             accessQ;
    logic [MODE_W-1:0]   modeQ;
    logic                bcdQ, wrHiQ, rdHiQ, stsHeldQ, nullQ, loadQ;
    logic [BYTE_W-1:0]   wrLowQ, stsQ, rdByte;
    logic [1:0]          cntHeldQ;   // 0 none, 1 low only, 2 high next, 3 low then high
    logic [COUNT_W-1:0]  heldCntQ, loadValQ, live, loadVal;
    logic                loadNow;

    assign live = chLiveCount[g*COUNT_W +: COUNT_W];

    always_comb begin
      loadNow = 1'b0;
      loadVal = '0;
      if (strb.dataWr[g]) begin
        unique case (accessQ)
          ACC_LO: begin loadNow = 1'b1; loadVal = {{BYTE_W{1'b0}}, strb.wrByte}; end
          ACC_HI: begin loadNow = 1'b1; loadVal = {strb.wrByte, {BYTE_W{1'b0}}}; end
          default: if (wrHiQ) begin loadNow = 1'b1; loadVal = {strb.wrByte, wrLowQ}; end
        endcase
      end
    end

    always_comb begin
      if (stsHeldQ)                                rdByte = stsQ;
      else if (cntHeldQ == 2'd1 || cntHeldQ == 2'd3) rdByte = heldCntQ[BYTE_W-1:0];
      else if (cntHeldQ == 2'd2)                   rdByte = heldCntQ[COUNT_W-1:BYTE_W];
      else begin
        unique case (accessQ)
          ACC_LO:  rdByte = live[BYTE_W-1:0];
          ACC_HI:  rdByte = live[COUNT_W-1:BYTE_W];
          default: rdByte = rdHiQ ? live[COUNT_W-1:BYTE_W] : live[BYTE_W-1:0];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accessQ  <= ACC_WORD;
        modeQ    <= '0;
        bcdQ     <= 1'b0;
        wrHiQ    <= 1'b0;
        rdHiQ    <= 1'b0;
        wrLowQ   <= '0;
        cntHeldQ <= 2'd0;
        heldCntQ <= '0;
        stsHeldQ <= 1'b0;
        stsQ     <= '0;
        nullQ    <= 1'b0;
        loadQ    <= 1'b0;
        loadValQ <= '0;
      end else begin
        loadQ <= loadNow;
        if (strb.cfgWr[g]) begin
          accessQ <= strb.access;
          modeQ   <= strb.mode;
          bcdQ    <= strb.bcd;
          wrHiQ   <= 1'b0;
          rdHiQ   <= 1'b0;
        end
        if (strb.cntCap[g] && cntHeldQ == 2'd0) begin
          cntHeldQ <= accessQ;
          heldCntQ <= live;
        end
        if (strb.stsCap[g] && !stsHeldQ) begin
          stsHeldQ <= 1'b1;
          stsQ     <= {chOut[g], nullQ, accessQ, modeQ, bcdQ};
        end
        if (strb.dataWr[g] && accessQ == ACC_WORD) begin
          wrHiQ <= ~wrHiQ;
          if (!wrHiQ) wrLowQ <= strb.wrByte;
        end
        if (loadNow) begin
          loadValQ <= loadVal;
          nullQ    <= 1'b1;
        end else if (chLoaded[g]) begin
          nullQ    <= 1'b0;
        end
        if (strb.dataRd[g]) begin
          if (stsHeldQ)                stsHeldQ <= 1'b0;
          else if (cntHeldQ != 2'd0)   cntHeldQ <= (cntHeldQ == 2'd3) ? 2'd2 : 2'd0;
          else if (accessQ == ACC_WORD) rdHiQ   <= ~rdHiQ;
        end
      end
    end

    assign chBytes[g*BYTE_W +: BYTE_W]      = rdByte;
    assign chLoad[g]                        = loadQ;
    assign chLoadValue[g*COUNT_W +: COUNT_W] = loadValQ;
    assign chMode[g*MODE_W +: MODE_W]       = modeQ;
    assign chBcd[g]                         = bcdQ;
  end

  logic [BYTE_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (strb.dataRd[c]) rdNext = chBytes[c*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= (|strb.dataRd) | strb.ctlRd;
      if ((|strb.dataRd) | strb.ctlRd) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/ivt_port.sv
module ivt_port
  import ivt_port_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [1:0]                 addr,
  input  logic [BYTE_W-1:0]          wrData,
  output logic [BYTE_W-1:0]          rdData,
  output logic                       rdValid,
  output logic [NUM_CH-1:0]          chLoad,
  output logic [NUM_CH*COUNT_W-1:0]  chLoadValue,
  input  logic [NUM_CH*COUNT_W-1:0]  chLiveCount,
  input  logic [NUM_CH-1:0]          chOut,
  input  logic [NUM_CH-1:0]          chLoaded,
  output logic [NUM_CH*MODE_W-1:0]   chMode,
  output logic [NUM_CH-1:0]          chBcd
);
  portStrobe_t strb;

  ivt_port_decode u_decode (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .strb(strb)
  );

  ivt_port_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .chLiveCount(chLiveCount), .chOut(chOut), .chLoaded(chLoaded),
    .chLoad(chLoad), .chLoadValue(chLoadValue), .chMode(chMode),
    .chBcd(chBcd), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/ivt_port_chk.sv
module ivt_port_chk
  import ivt_port_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic                       rdEn,
  input logic [1:0]                 addr,
  input logic [BYTE_W-1:0]          rdData,
  input logic                       rdValid,
  input logic [NUM_CH-1:0]          chLoad,
  input logic [NUM_CH*COUNT_W-1:0]  chLoadValue,
  input logic [NUM_CH*MODE_W-1:0]   chMode
);
  assert_load_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chLoad));

  assert_load_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|chLoad) |-> $past(wrEn && addr != 2'd3));

  assert_value_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chLoadValue != $past(chLoadValue)) |-> (|chLoad));

  assert_mode_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    (chMode != $past(chMode)) |-> $past(wrEn && addr == 2'd3));

  for (genvar g = 0; g < NUM_CH; g++) begin : gMode
    assert_mode_folded_R3: assert property (@(posedge clk) disable iff (!rstN)
      chMode[g*MODE_W +: MODE_W] <= 3'd5);
  end

  assert_rdvalid_R12: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn && !wrEn));

  assert_ctl_read_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(addr == 2'd3)) |-> (rdData == '0));
endmodule

bind ivt_port ivt_port_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .rdValid(rdValid), .chLoad(chLoad),
  .chLoadValue(chLoadValue), .chMode(chMode)
);

// File: tb/ivt_port_bench.sv
module ivt_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [2:0]  chLoad;
  logic [47:0] chLoadValue;
  logic [15:0] live [3];
  logic [47:0] chLiveCount;
  logic [2:0]  chOut = 3'b000, chLoaded = 3'b000;
  logic [8:0]  chMode;
  logic [2:0]  chBcd;

  int checks = 0, failures = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #10 clk = ~clk;
  assign chLiveCount = {live[2], live[1], live[0]};

  ivt_port u_ivt_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .chLoad(chLoad),
    .chLoadValue(chLoadValue), .chLiveCount(chLiveCount), .chOut(chOut),
    .chLoaded(chLoaded), .chMode(chMode), .chBcd(chBcd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bytes as read results appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check(1'b0, "R12 unexpected rdValid", {24'h0, rdData}, 32'h0);
      else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(rdData == e, t, {24'h0, rdData}, {24'h0, e});
      end
    end
  end

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [7:0] e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic expectLoad(input int ch, input logic [15:0] v, input string t);
    check(chLoad == 3'(1 << ch) && chLoadValue[ch*16 +: 16] == v, t,
          {13'h0, chLoad, chLoadValue[ch*16 +: 16]}, {13'h0, 3'(1 << ch), v});
  endtask

  task automatic expectNoLoad(input string t);
    check(chLoad == 3'b000, t, {29'h0, chLoad}, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog expired", 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    live[0] = 16'h0; live[1] = 16'h0; live[2] = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(chLoad == 0 && rdValid == 0, "R1 strobes idle", {28'h0, chLoad, rdValid}, 0);
    check(chMode == 0 && chBcd == 0, "R1 mode/bcd", {20'h0, chMode, chBcd}, 0);
    doWrite(2'd3, 8'hE2);                       // read-back status ch0
    doRead(2'd0, 8'h30, "R1 R6 reset status");

    // R2 control word, R3 folding
    doWrite(2'd3, 8'h35);                       // ch0 word, mode 2, bcd 1
    check(chMode[2:0] == 3'd2 && chBcd[0], "R2 ch0 config", {28'h0, chBcd[0], chMode[2:0]}, 32'hA);
    doWrite(2'd3, 8'h7C);                       // ch1 mode 6 -> 2
    check(chMode[5:3] == 3'd2, "R3 fold 6", {29'h0, chMode[5:3]}, 2);
    doWrite(2'd3, 8'h9E);                       // ch2 low only, mode 7 -> 3
    check(chMode[8:6] == 3'd3, "R3 fold 7", {29'h0, chMode[8:6]}, 3);
    doWrite(2'd3, 8'h60);                       // ch1 high only, mode 0
    check(chMode[5:3] == 3'd0, "R2 ch1 reconfig", {29'h0, chMode[5:3]}, 0);

    // R9 write assembly
    doWrite(2'd0, 8'h34);
    expectNoLoad("R9 word first byte");
    doWrite(2'd0, 8'h12);
    expectLoad(0, 16'h1234, "R9 word load");
    doWrite(2'd2, 8'hAB);
    expectLoad(2, 16'h00AB, "R9 low only");
    doWrite(2'd1, 8'hCD);
    expectLoad(1, 16'hCD00, "R9 high only");

    // R11 null count, R6 status format
    chOut[0] = 1'b1;
    doWrite(2'd3, 8'hE2);
    doRead(2'd0, 8'hF5, "R6 R11 status null set");
    chLoaded[0] = 1'b1; @(negedge clk); chLoaded[0] = 1'b0;
    doWrite(2'd3, 8'hE2);
    doRead(2'd0, 8'hB5, "R11 null cleared");

    // R10 live word toggle
    live[0] = 16'hBEEF;
    doRead(2'd0, 8'hEF, "R10 live low");
    doRead(2'd0, 8'hBE, "R10 live high");
    doRead(2'd0, 8'hEF, "R10 live low again");

    // R4 counter capture
    doWrite(2'd3, 8'h00);
    live[0] = 16'h1122;
    doRead(2'd0, 8'hEF, "R4 captured low");
    doRead(2'd0, 8'hBE, "R4 captured high");
    doRead(2'd0, 8'h11, "R4 R10 live after capture");

    // R7 second capture ignored
    live[2] = 16'h0042;
    doWrite(2'd3, 8'h80);
    live[2] = 16'h0099;
    doWrite(2'd3, 8'h80);
    doRead(2'd2, 8'h42, "R7 first capture kept");
    doRead(2'd2, 8'h99, "R7 R10 live low only");

    // R8 priority, R5 read-back both
    live[1] = 16'h5A00;
    doWrite(2'd3, 8'hC4);
    live[1] = 16'h7700;
    doRead(2'd1, 8'h60, "R8 status first");
    doRead(2'd1, 8'h5A, "R8 count second");
    doRead(2'd1, 8'h77, "R8 R10 live high only");

    // R5 multi-channel read-back, count only
    live[0] = 16'h3344; live[2] = 16'h0066;
    doWrite(2'd3, 8'hDA);
    live[0] = 16'h0000; live[2] = 16'h0000; live[1] = 16'h8800;
    doRead(2'd0, 8'h44, "R5 ch0 low");
    doRead(2'd0, 8'h33, "R5 ch0 high");
    doRead(2'd2, 8'h66, "R5 ch2");
    doRead(2'd1, 8'h88, "R5 ch1 unselected");

    // R13 control word resets write toggle
    doWrite(2'd0, 8'h99);
    expectNoLoad("R13 first byte");
    doWrite(2'd3, 8'h35);
    doWrite(2'd0, 8'h77);
    expectNoLoad("R13 toggle reset");
    doWrite(2'd0, 8'h66);
    expectLoad(0, 16'h6677, "R13 load after reset");

    // R12 control read and simultaneous access
    doRead(2'd3, 8'h00, "R12 control read");
    @(negedge clk); addr = 2'd0; wrData = 8'h55; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    check(rdValid == 1'b0, "R12 read dropped", {31'h0, rdValid}, 0);
    doWrite(2'd0, 8'h01);
    expectLoad(0, 16'h0155, "R12 write kept");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R12 reads all returned", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule